// File: doc/BRIEF.md
# Pointer-Capable CPU Register Bank

This block is the working register store of a small 8-bit processor core. It holds thirty-two byte-wide registers. Two read ports serve operands to the ALU, and one write port takes results back. An immediate-form flag folds a 4-bit register field onto the upper sixteen registers. These are the only registers that constant-operand instructions may name.

The same registers also sit at the bottom of the data address space, at addresses 0x00 to 0x1F. A load/store port can reach them there and reports whether an address hit the bank. Accesses that miss are left for external SRAM.

The six highest registers pair up into three 16-bit pointers, named X, Y and Z. The pointer logic can form an address from a pointer in four ways:

- plain: the pointer value as it stands;
- displacement: the pointer plus a small unsigned offset;
- post-increment: the pointer value, with pointer+1 written back;
- pre-decrement: pointer−1, which is also written back.

Whenever a pointer request is active, its address replaces the direct data address. An indirect access can therefore land on any register, including the pointer's own bytes.

The block has no sequencing states. Each cycle's reads are combinational and all writes commit at one clock edge. The only transition is reset, which clears the whole bank to zero.

Top module: `gpr_bank`

## Requirements
- R1: While rst_n is low, and at the first edge after it rises, every register reads 0x00.
- R2: With wr_en high, wr_data is stored in the selected register at the next rising clk edge. Both read ports return any register's contents combinationally.
- R3: When rd_a_imm or wr_imm is 1, the register used is 16 plus bits [3:0] of the index, and index bit 4 is ignored.
- R4: The data-space address is ptr_addr when ptr_req is 1, and ds_addr otherwise. With ds_en high and that address below 0x20, ds_hit is 1 and ds_rdata returns register n for address n. A write with ds_we stores ds_wdata into register n. At 0x20 or above, ds_hit is 0, ds_rdata is 0x00 and no register changes.
- R5: ptr_sel picks the pointer: 0 is X (R27:R26), 1 is Y (R29:R28), 2 and 3 are Z (R31:R30). The odd register is the high byte.
- R6: ptr_mode selects the addressing form: 0 plain, 1 displacement, 2 post-increment, 3 pre-decrement. Post-increment outputs the old value and writes value+1. Pre-decrement outputs value−1 and writes it back. Both writes cover the full 16 bits and wrap modulo 2^16.
- R7: Displacement mode outputs Y or Z plus ptr_disp (0 to 63) and leaves the pointer unchanged. With X, the offset is ignored and the address is X itself.
- R8: ds_rdata and both read ports return the value the register holds after the current edge. This includes a value being written in the same cycle.
- R9: If several writes target one register in a cycle, the byte write port wins over a data-space write, and a data-space write wins over a pointer update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the bank |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_imm | input | 1 | Port A uses the upper-half mapping |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_imm | input | 1 | Write index uses the upper-half mapping |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| ds_en | input | 1 | Data-space access enable |
| ds_we | input | 1 | Data-space write enable |
| ds_addr | input | 16 | Direct data-space address |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| ds_hit | output | 1 | Access falls inside the register bank |
| ptr_req | input | 1 | Use a pointer for this access |
| ptr_sel | input | 2 | Pointer select |
| ptr_mode | input | 2 | Addressing form |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_addr | output | 16 | Effective address from the pointer |

## Verification
A vector table first loads the three pointers. It then tries each addressing form, with Y and Z loaded so that the carry into the high byte, the borrow out of it and a displacement landing on X's low byte all occur. This separates an 8-bit from a 16-bit update and shows whether aliased writes reach the bank. Direct data-space accesses just inside and just outside 0x1F separate a correct hit decode from an off-by-one decode. A random phase mixes every port against a behavioural array model. Directed cycles then stack the byte write, a data-space write and a pointer update on one register, and wrap Z through 0xFFFF, so that each level of the write priority is pinned down on its own.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
    localparam int unsigned GPR_DW       = 8;
    localparam int unsigned GPR_NREG     = 32;
    localparam int unsigned GPR_PTR_BASE = 26;
    localparam int unsigned GPR_DISP_W   = 6;

    typedef enum logic [1:0] {
        PSEL_X   = 2'd0,
        PSEL_Y   = 2'd1,
        PSEL_Z   = 2'd2,
        PSEL_ZA  = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_DISP    = 2'd1,
        AM_POSTINC = 2'd2,
        AM_PREDEC  = 2'd3
    } addr_mode_e;
endpackage

// File: rtl/gpr_ptr_unit.sv
`timescale 1ns/1ps
module gpr_ptr_unit
    import gpr_pkg::*;
#(
    parameter int DW       = GPR_DW,
    parameter int NREG     = GPR_NREG,
    parameter int PTR_BASE = GPR_PTR_BASE,
    parameter int DISP_W   = GPR_DISP_W,
    localparam int IDX_W   = $clog2(NREG),
    localparam int AW      = 2 * DW
) (
    input  logic [5:0][DW-1:0]  ptr_regs,
    input  logic                ptr_req,
    input  logic [1:0]          ptr_sel,
    input  logic [1:0]          ptr_mode,
    input  logic [DISP_W-1:0]   ptr_disp,
    output logic [AW-1:0]       ptr_addr,
    output logic                upd_en,
    output logic [IDX_W-1:0]    upd_lo_idx,
    output logic [AW-1:0]       upd_val
);
    ptr_sel_e   sel_e;
    addr_mode_e mode_e;
    logic [AW-1:0] cur_val;
    logic [AW-1:0] inc_val;
    logic [AW-1:0] dec_val;
    logic [AW-1:0] off_val;
    logic          wants_upd;

    always_comb begin
        sel_e = ptr_sel_e'(ptr_sel);
        unique case (sel_e)
            PSEL_X: begin
                cur_val    = {ptr_regs[1], ptr_regs[0]};
                upd_lo_idx = IDX_W'(PTR_BASE);
                off_val    = '0;
            end
            PSEL_Y: begin
                cur_val    = {ptr_regs[3], ptr_regs[2]};
                upd_lo_idx = IDX_W'(PTR_BASE + 2);
                off_val    = AW'(ptr_disp);
            end
            default: begin
                cur_val    = {ptr_regs[5], ptr_regs[4]};
                upd_lo_idx = IDX_W'(PTR_BASE + 4);
                off_val    = AW'(ptr_disp);
            end
        endcase
    end

    assign inc_val = cur_val + AW'(1);
    assign dec_val = cur_val - AW'(1);

    always_comb begin
        mode_e = addr_mode_e'(ptr_mode);
        unique case (mode_e)
            AM_PLAIN: begin
                ptr_addr  = cur_val;
                upd_val   = cur_val;
                wants_upd = 1'b0;
            end
            AM_DISP: begin
                ptr_addr  = cur_val + off_val;
                upd_val   = cur_val;
                wants_upd = 1'b0;
            end
            AM_POSTINC: begin
                ptr_addr  = cur_val;
                upd_val   = inc_val;
                wants_upd = 1'b1;
            end
            default: begin
                ptr_addr  = dec_val;
                upd_val   = dec_val;
                wants_upd = 1'b1;
            end
        endcase
        upd_en = ptr_req & wants_upd;
    end
endmodule

// File: rtl/gpr_write_arb.sv
`timescale 1ns/1ps
module gpr_write_arb
    import gpr_pkg::*;
#(
    parameter int DW     = GPR_DW,
    parameter int NREG   = GPR_NREG,
    localparam int IDX_W = $clog2(NREG),
    localparam int AW    = 2 * DW
) (
    input  logic [NREG-1:0][DW-1:0] cur,
    input  logic                    byte_we,
    input  logic [IDX_W-1:0]        byte_idx,
    input  logic [DW-1:0]           byte_data,
    input  logic                    ds_wr,
    input  logic [IDX_W-1:0]        ds_idx,
    input  logic [DW-1:0]           ds_data,
    input  logic                    upd_en,
    input  logic [IDX_W-1:0]        upd_lo_idx,
    input  logic [AW-1:0]           upd_val,
    output logic [NREG-1:0][DW-1:0] nxt
);
    logic [IDX_W-1:0] upd_hi_idx;
    assign upd_hi_idx = upd_lo_idx | IDX_W'(1);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic [DW-1:0] slot_v;
        always_comb begin
            slot_v = cur[i];
            if (upd_en && upd_lo_idx == IDX_W'(i)) slot_v = upd_val[DW-1:0];
            if (upd_en && upd_hi_idx == IDX_W'(i)) slot_v = upd_val[AW-1:DW];
            if (ds_wr && ds_idx == IDX_W'(i))      slot_v = ds_data;
            if (byte_we && byte_idx == IDX_W'(i))  slot_v = byte_data;
        end
        assign nxt[i] = slot_v;
    end
endmodule

// File: rtl/gpr_read_mux.sv
`timescale 1ns/1ps
module gpr_read_mux
    import gpr_pkg::*;
#(
    parameter int DW     = GPR_DW,
    parameter int NREG   = GPR_NREG,
    parameter int NPORT  = 3,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][DW-1:0]   src,
    input  logic [NPORT-1:0][IDX_W-1:0] idx,
    output logic [NPORT-1:0][DW-1:0]  data
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign data[p] = src[idx[p]];
    end
endmodule

// File: rtl/gpr_bank.sv
`timescale 1ns/1ps
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int DW       = GPR_DW,
    parameter int NREG     = GPR_NREG,
    parameter int PTR_BASE = GPR_PTR_BASE,
    parameter int DISP_W   = GPR_DISP_W,
    localparam int IDX_W   = $clog2(NREG),
    localparam int AW      = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic              rd_a_imm,
    output logic [DW-1:0]     rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic              wr_imm,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              ds_en,
    input  logic              ds_we,
    input  logic [AW-1:0]     ds_addr,
    input  logic [DW-1:0]     ds_wdata,
    output logic [DW-1:0]     ds_rdata,
    output logic              ds_hit,
    input  logic              ptr_req,
    input  logic [1:0]        ptr_sel,
    input  logic [1:0]        ptr_mode,
    input  logic [DISP_W-1:0] ptr_disp,
    output logic [AW-1:0]     ptr_addr
);
    logic [NREG-1:0][DW-1:0] regs_q;
    logic [NREG-1:0][DW-1:0] regs_d;

    logic [IDX_W-1:0] rd_a_tgt;
    logic [IDX_W-1:0] wr_tgt;
    logic [AW-1:0]    eff_addr;
    logic [IDX_W-1:0] ds_idx;
    logic             ds_wr;
    logic             upd_en;
    logic [IDX_W-1:0] upd_lo_idx;
    logic [AW-1:0]    upd_val;

    logic [2:0][IDX_W-1:0] port_idx;
    logic [2:0][DW-1:0]    port_data;

    assign rd_a_tgt = rd_a_imm ? {1'b1, rd_a_idx[IDX_W-2:0]} : rd_a_idx;
    assign wr_tgt   = wr_imm   ? {1'b1, wr_idx[IDX_W-2:0]}   : wr_idx;

    gpr_ptr_unit #(
        .DW(DW), .NREG(NREG), .PTR_BASE(PTR_BASE), .DISP_W(DISP_W)
    ) u_ptr (
        .ptr_regs   (regs_q[PTR_BASE+5:PTR_BASE]),
        .ptr_req    (ptr_req),
        .ptr_sel    (ptr_sel),
        .ptr_mode   (ptr_mode),
        .ptr_disp   (ptr_disp),
        .ptr_addr   (ptr_addr),
        .upd_en     (upd_en),
        .upd_lo_idx (upd_lo_idx),
        .upd_val    (upd_val)
    );

    assign eff_addr = ptr_req ? ptr_addr : ds_addr;
    assign ds_hit   = ds_en && (eff_addr < AW'(NREG));
    assign ds_idx   = eff_addr[IDX_W-1:0];
    assign ds_wr    = ds_hit && ds_we;

    gpr_write_arb #(.DW(DW), .NREG(NREG)) u_arb (
        .cur        (regs_q),
        .byte_we    (wr_en),
        .byte_idx   (wr_tgt),
        .byte_data  (wr_data),
        .ds_wr      (ds_wr),
        .ds_idx     (ds_idx),
        .ds_data    (ds_wdata),
        .upd_en     (upd_en),
        .upd_lo_idx (upd_lo_idx),
        .upd_val    (upd_val),
        .nxt        (regs_d)
    );

    assign port_idx = {ds_idx, rd_b_idx, rd_a_tgt};

    gpr_read_mux #(.DW(DW), .NREG(NREG), .NPORT(3)) u_rd (
        .src  (regs_d),
        .idx  (port_idx),
        .data (port_data)
    );

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];
    assign ds_rdata  = ds_hit ? port_data[2] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/gpr_bank_chk.sv
`timescale 1ns/1ps
module gpr_bank_chk #(
    parameter int DW     = 8,
    parameter int NREG   = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int AW    = 2 * DW
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NREG-1:0][DW-1:0] regs_q,
    input logic                    wr_en,
    input logic [IDX_W-1:0]        wr_tgt,
    input logic [DW-1:0]           wr_data,
    input logic [IDX_W-1:0]        rd_a_tgt,
    input logic [DW-1:0]           rd_a_data,
    input logic                    ds_en,
    input logic                    ds_we,
    input logic                    ds_hit,
    input logic [AW-1:0]           eff_addr,
    input logic                    ptr_req,
    input logic [1:0]              ptr_sel,
    input logic [1:0]              ptr_mode,
    input logic [AW-1:0]           ptr_addr
);
    function automatic logic [AW-1:0] pair_of(input logic [NREG-1:0][DW-1:0] r,
                                              input logic [1:0] s);
        case (s)
            2'd0:    return {r[NREG-5], r[NREG-6]};
            2'd1:    return {r[NREG-3], r[NREG-4]};
            default: return {r[NREG-1], r[NREG-2]};
        endcase
    endfunction

    // R2
    byte_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_tgt)] == $past(wr_data));

    // R8
    write_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_a_tgt == wr_tgt) |-> rd_a_data == wr_data);

    // R4
    hit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_en |-> ds_hit == (eff_addr < AW'(NREG)));

    // R6
    postinc_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && ptr_mode == 2'd2 && !wr_en && !(ds_hit && ds_we))
        |=> pair_of(regs_q, $past(ptr_sel)) == $past(ptr_addr) + AW'(1));

    // R6
    predec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && ptr_mode == 2'd3) |-> ptr_addr == pair_of(regs_q, ptr_sel) - AW'(1));

    // R7
    disp_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && ptr_mode == 2'd1 && !wr_en && !(ds_hit && ds_we)) |=> $stable(regs_q));
endmodule

bind gpr_bank gpr_bank_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .regs_q    (regs_q),
    .wr_en     (wr_en),
    .wr_tgt    (wr_tgt),
    .wr_data   (wr_data),
    .rd_a_tgt  (rd_a_tgt),
    .rd_a_data (rd_a_data),
    .ds_en     (ds_en),
    .ds_we     (ds_we),
    .ds_hit    (ds_hit),
    .eff_addr  (eff_addr),
    .ptr_req   (ptr_req),
    .ptr_sel   (ptr_sel),
    .ptr_mode  (ptr_mode),
    .ptr_addr  (ptr_addr)
);

// File: tb/tb_gpr_bank.sv
`timescale 1ns/1ps
module tb_gpr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        rd_a_imm, wr_imm, wr_en, ds_en, ds_we, ptr_req;
    logic [7:0]  rd_a_data, rd_b_data, wr_data, ds_wdata, ds_rdata;
    logic [15:0] ds_addr, ptr_addr;
    logic        ds_hit;
    logic [1:0]  ptr_sel, ptr_mode;
    logic [5:0]  ptr_disp;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] m [32];

    always #4 clk = ~clk;

    gpr_bank dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_imm(rd_a_imm), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_imm(wr_imm), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_en(ds_en), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
        .ds_rdata(ds_rdata), .ds_hit(ds_hit),
        .ptr_req(ptr_req), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode),
        .ptr_disp(ptr_disp), .ptr_addr(ptr_addr)
    );

    // kind[27:24] sel[23:16] val[15:0]
    // 0 byte write R[sel]=val; 1 imm write field sel; 2 ds write addr val data sel
    // 3 ds read addr val; 4 ptr read (sel[5:4] ptr, sel[1:0] mode, val disp)
    // 5 ptr write (as 4, data val[15:8], disp val[5:0])
    localparam logic [27:0] VEC [20] = '{
        {4'd0, 8'd26, 16'h0010}, {4'd0, 8'd27, 16'h0000},
        {4'd1, 8'd12, 16'h0005}, {4'd1, 8'd13, 16'h0000},
        {4'd0, 8'd30, 16'h00FF}, {4'd0, 8'd31, 16'h0000},
        {4'd2, 8'hA5, 16'h0003}, {4'd3, 8'h00, 16'h0003},
        {4'd3, 8'h00, 16'h0020}, {4'd2, 8'h66, 16'h001F},
        {4'd4, 8'h00, 16'h0000}, {4'd5, 8'h02, 16'h3C00},
        {4'd4, 8'h22, 16'h0000}, {4'd4, 8'h23, 16'h0000},
        {4'd4, 8'h11, 16'h000A}, {4'd5, 8'h11, 16'h9915},
        {4'd4, 8'h01, 16'h003F}, {4'd4, 8'h30, 16'h0000},
        {4'd5, 8'h23, 16'h4400}, {4'd0, 8'd5,  16'h005A}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic idle_in();
        rd_a_idx = '0; rd_a_imm = 1'b0; rd_b_idx = '0;
        wr_en = 1'b0; wr_imm = 1'b0; wr_idx = '0; wr_data = '0;
        ds_en = 1'b0; ds_we = 1'b0; ds_addr = '0; ds_wdata = '0;
        ptr_req = 1'b0; ptr_sel = '0; ptr_mode = '0; ptr_disp = '0;
    endtask

    task automatic apply(input logic we, input logic wimm, input logic [4:0] widx,
                         input logic [7:0] wdat, input logic dse, input logic dswe,
                         input logic [15:0] dsa, input logic [7:0] dsd, input logic pr,
                         input logic [1:0] psel, input logic [1:0] pm, input logic [5:0] pd);
        logic [7:0]  nm [32];
        int          base;
        logic [15:0] pv, ea, eff, nv;
        logic        hit;
        logic [4:0]  tgt;
        @(negedge clk);
        wr_en = we; wr_imm = wimm; wr_idx = widx; wr_data = wdat;
        ds_en = dse; ds_we = dswe; ds_addr = dsa; ds_wdata = dsd;
        ptr_req = pr; ptr_sel = psel; ptr_mode = pm; ptr_disp = pd;
        rd_a_idx = widx; rd_a_imm = wimm;
        base = (psel == 2'd0) ? 26 : (psel == 2'd1) ? 28 : 30;
        pv = {m[base+1], m[base]};
        case (pm)
            2'd0: begin ea = pv; nv = pv; end
            2'd1: begin ea = pv + ((psel == 2'd0) ? 16'd0 : 16'(pd)); nv = pv; end
            2'd2: begin ea = pv; nv = pv + 16'd1; end
            default: begin ea = pv - 16'd1; nv = ea; end
        endcase
        eff = pr ? ea : dsa;
        hit = dse && (eff < 16'h0020);
        tgt = wimm ? {1'b1, widx[3:0]} : widx;
        nm = m;
        if (pr && pm[1]) begin nm[base] = nv[7:0]; nm[base+1] = nv[15:8]; end
        if (hit && dswe) nm[eff[4:0]] = dsd;
        if (we) nm[tgt] = wdat;
        rd_b_idx = hit ? eff[4:0] : 5'd0;
        #1;
        if (pr) chk("R5/R6/R7 ptr_addr", ptr_addr, ea);
        chk("R4 ds_hit", 16'(ds_hit), 16'(hit));
        chk("R4/R8 ds_rdata", 16'(ds_rdata), hit ? 16'(nm[eff[4:0]]) : 16'h0);
        chk("R3/R8 rd_a_data", 16'(rd_a_data), 16'(nm[tgt]));
        @(posedge clk);
        m = nm;
        #1 idle_in();
    endtask

    task automatic read_reg(input int i, input logic [7:0] exp, input string req);
        @(negedge clk);
        idle_in();
        rd_b_idx = 5'(i);
        #1 chk(req, 16'(rd_b_data), 16'(exp));
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 32; i++) read_reg(i, m[i], req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check_all("R1 reset");

        // table walk
        for (int v = 0; v < 20; v++) begin
            logic [3:0] k;
            logic [7:0] s;
            logic [15:0] d;
            {k, s, d} = VEC[v];
            case (k)
                4'd0: apply(1, 0, s[4:0], d[7:0], 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
                4'd1: apply(1, 1, s[4:0], d[7:0], 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
                4'd2: apply(0, 0, 5'd0, 8'h0, 1, 1, d, s, 0, 2'd0, 2'd0, 6'd0);
                4'd3: apply(0, 0, 5'd0, 8'h0, 1, 0, d, 8'h0, 0, 2'd0, 2'd0, 6'd0);
                4'd4: apply(0, 0, 5'd0, 8'h0, 1, 0, 16'h0, 8'h0, 1, s[5:4], s[1:0], d[5:0]);
                default: apply(0, 0, 5'd0, 8'h0, 1, 1, 16'h0, d[15:8], 1, s[5:4], s[1:0], d[5:0]);
            endcase
        end
        // R2 contents after table
        check_all("R2 table contents");

        // random mix against the model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r0, r1;
            r0 = $urandom; r1 = $urandom;
            apply(r0[0], r0[1], r0[6:2], r0[14:7], r0[15], r0[16],
                  r0[17] ? {8'h00, 3'b000, r1[4:0]} : r1[15:0], r1[23:16],
                  r0[18], r0[20:19], r0[22:21], r0[28:23]);
        end
        check_all("R2 random contents");

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        @(negedge clk); rst_n = 1'b1;
        check_all("R1 reset after traffic");

        // R6 wrap of Z through 0xFFFF
        apply(1, 0, 5'd30, 8'hFF, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(1, 0, 5'd31, 8'hFF, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(0, 0, 5'd0, 8'h0, 0, 0, 16'h0, 8'h0, 1, 2'd2, 2'd2, 6'd0);
        read_reg(30, 8'h00, "R6 wrap low");
        read_reg(31, 8'h00, "R6 wrap high");

        // R6 carry into high byte: X=0x00FF post-increment
        apply(1, 0, 5'd26, 8'hFF, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(0, 0, 5'd0, 8'h0, 0, 0, 16'h0, 8'h0, 1, 2'd0, 2'd2, 6'd0);
        read_reg(26, 8'h00, "R6 carry low");
        read_reg(27, 8'h01, "R6 carry high");

        // R9 byte write beats data-space write beats pointer update, X=0x001A
        apply(1, 0, 5'd26, 8'h1A, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(1, 0, 5'd27, 8'h00, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(1, 0, 5'd26, 8'h77, 1, 1, 16'h0, 8'h55, 1, 2'd0, 2'd2, 6'd0);
        read_reg(26, 8'h77, "R9 byte write first");
        read_reg(27, 8'h00, "R9 high byte from update");
        apply(1, 0, 5'd26, 8'h1A, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(0, 0, 5'd0, 8'h0, 1, 1, 16'h0, 8'h55, 1, 2'd0, 2'd2, 6'd0);
        read_reg(26, 8'h55, "R9 data-space over update");
        apply(1, 0, 5'd27, 8'h44, 0, 0, 16'h0, 8'h0, 1, 2'd0, 2'd3, 6'd0);
        read_reg(27, 8'h44, "R9 byte write over high update");
        read_reg(26, 8'h54, "R9 low byte still updated");

        // R3 immediate mapping ignores index bit 4
        apply(1, 1, 5'b00011, 8'h3B, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        read_reg(19, 8'h3B, "R3 imm write to R19");
        read_reg(3, 8'h00, "R3 R3 untouched");

        // R4 write just outside the window changes nothing
        apply(0, 0, 5'd0, 8'h0, 1, 1, 16'h0020, 8'hEE, 0, 2'd0, 2'd0, 6'd0);
        apply(0, 0, 5'd0, 8'h0, 1, 1, 16'h001F, 8'hC3, 0, 2'd0, 2'd0, 6'd0);
        read_reg(31, 8'hC3, "R4 edge address 0x1F");
        check_all("R4 no stray write");

        // R7 displacement 63 on Y, pointer kept
        apply(1, 0, 5'd28, 8'h10, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(1, 0, 5'd29, 8'h00, 0, 0, 16'h0, 8'h0, 0, 2'd0, 2'd0, 6'd0);
        apply(0, 0, 5'd0, 8'h0, 1, 0, 16'h0, 8'h0, 1, 2'd1, 2'd1, 6'd63);
        read_reg(28, 8'h10, "R7 Y unchanged");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule